// File: doc/BRIEF.md
# Peripheral Access Protection Checker

This block sits between one bus master port and a bank of peripheral slots. For every request it decides whether the access may reach the addressed peripheral. If it may not, the block ends the request with an error response and starts no peripheral cycle.

Each slot has a 3-bit protection setting that is shown as a 4-bit nibble in a 32-bit control word. One word covers eight slots. Software reads and writes these words through a small register port. A request carries four attributes: the slot index, the direction, a supervisor flag and a trusted-master flag. The requesting master's privilege-enable bit comes from a vector input. Each protection bit enables one gating check on its own. A request passes only if none of the enabled checks fails.

The block has one request in flight at a time. It forms the decision combinationally when it accepts a request. The response appears one cycle later and is held until the master takes it.

Top module: `periph_guard`

## Requirements
- R1: After reset every implemented control word reads 0x44444444. Every slot starts supervisor-only, with writes allowed and untrusted masters allowed.
- R2: Slot 8g+p sits in word g at nibble bits [31-4p : 28-4p]. Inside a nibble, bit 3 is reserved, bit 2 is supervisor-only, bit 1 is write-protect and bit 0 is trusted-only. The reserved bit and the nibbles of unimplemented slots always read 0, and writes to them have no effect.
- R3: Word g lives at byte address BASE_OFS + 4g, and BASE_OFS defaults to 0x20. Any other address reads 0, and writes to it change no setting.
- R4: If a slot is supervisor-only, an access to it passes only when req_super is 1 and mst_priv[req_master] is 1.
- R5: If a slot is write-protected, every write to it fails. Reads to it are unaffected.
- R6: If a slot is trusted-only, every access with req_trusted = 0 fails.
- R7: A failed access gives rsp_err = 1 and no per_start pulse. A passing access gives rsp_err = 0 and a one-cycle per_start pulse, with per_slot and per_write taken from the request.
- R8: A slot index at or above NUM_SLOTS always fails with an error.
- R9: A request is accepted when req_valid and req_ready are both 1. rsp_valid rises on the next cycle. rsp_valid and rsp_err stay fixed until rsp_ready is 1. req_ready is 0 while a response is waiting and rsp_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mst_priv | input | NUM_MASTERS | Privilege-enable bit for each master |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_slot | input | SLOT_W | Target slot index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | Supervisor attribute |
| req_trusted | input | 1 | Requesting master is trusted |
| req_master | input | MST_W | Requesting master index |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Access was refused |
| per_start | output | 1 | One-cycle peripheral access start |
| per_slot | output | SLOT_W | Slot of the started access |
| per_write | output | 1 | Direction of the started access |

## Verification
The bench builds the block with NUM_SLOTS = 20 and SLOT_W = 5. The third control word is therefore half populated: slots 20 to 23 exist only as dead nibbles, and slots 20 to 31 can be requested but lie out of range. It uses four masters, so that only some of them hold privilege while supervisor checks run. It also holds rsp_ready low at random, which keeps requests waiting behind an unretired response. Random register writes land on mapped, unmapped and misaligned addresses while accesses are in flight.

// File: rtl/periph_guard.sv
module periph_guard #(
  parameter int NUM_SLOTS   = 32,
  parameter int SLOT_W      = 6,
  parameter int NUM_MASTERS = 4,
  parameter int MST_W       = 2,
  parameter int CFG_AW      = 8,
  parameter int BASE_OFS    = 32'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [NUM_MASTERS-1:0] mst_priv,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [SLOT_W-1:0]      req_slot,
  input  logic                   req_write,
  input  logic                   req_super,
  input  logic                   req_trusted,
  input  logic [MST_W-1:0]       req_master,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_err,
  output logic                   per_start,
  output logic [SLOT_W-1:0]      per_slot,
  output logic                   per_write
);
  localparam int NUM_GROUPS = (NUM_SLOTS + 7) / 8;
  localparam int IDX_W      = CFG_AW - 2;

  logic [NUM_SLOTS-1:0] sp_q, wp_q, tp_q;

  logic [CFG_AW-1:0] rel;
  logic [IDX_W-1:0]  cfg_idx;
  logic              cfg_hit;
  logic              cfg_unused;

  assign rel        = cfg_addr - BASE_OFS[CFG_AW-1:0];
  assign cfg_idx    = rel[CFG_AW-1:2];
  assign cfg_hit    = (cfg_addr >= BASE_OFS[CFG_AW-1:0]) && (rel[1:0] == 2'b00) &&
                      (cfg_idx < IDX_W'(NUM_GROUPS));
  assign cfg_unused = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '1;
      wp_q <= '0;
      tp_q <= '0;
    end else if (cfg_we && cfg_hit) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cfg_idx == IDX_W'(s / 8)) begin
          sp_q[s] <= cfg_wdata[30 - 4 * (s % 8)];
          wp_q[s] <= cfg_wdata[29 - 4 * (s % 8)];
          tp_q[s] <= cfg_wdata[28 - 4 * (s % 8)];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_hit) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cfg_idx == IDX_W'(s / 8)) begin
          cfg_rdata[30 - 4 * (s % 8)] = sp_q[s];
          cfg_rdata[29 - 4 * (s % 8)] = wp_q[s];
          cfg_rdata[28 - 4 * (s % 8)] = tp_q[s];
        end
      end
    end
  end

  logic sp_sel, wp_sel, tp_sel, priv_sel, in_range, grant, accept;

  always_comb begin
    sp_sel = 1'b0;
    wp_sel = 1'b0;
    tp_sel = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (req_slot == SLOT_W'(s)) begin
        sp_sel = sp_q[s];
        wp_sel = wp_q[s];
        tp_sel = tp_q[s];
      end
    end
    priv_sel = 1'b0;
    for (int m = 0; m < NUM_MASTERS; m++)
      if (req_master == MST_W'(m)) priv_sel = mst_priv[m];
  end

  assign in_range  = 32'(req_slot) < 32'(NUM_SLOTS);
  assign grant     = in_range &&
                     !(sp_sel && !(req_super && priv_sel)) &&
                     !(wp_sel && req_write) &&
                     !(tp_sel && !req_trusted);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      per_start <= 1'b0;
      per_slot  <= '0;
      per_write <= 1'b0;
    end else begin
      per_start <= accept && grant;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_err   <= !grant;
        per_slot  <= req_slot;
        per_write <= req_write;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 32'h8888_8888) == 32'h0);

  // R5
  write_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && wp_sel |=> rsp_valid && rsp_err && !per_start);

  // R7
  start_only_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_start |-> rsp_valid && !rsp_err);

  // R8
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_range |=> rsp_valid && rsp_err);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_err));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

// File: tb/sim_periph_guard.sv
module sim_periph_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 20;
  localparam int SW  = 5;
  localparam int NM  = 4;
  localparam int MW  = 2;
  localparam int AW  = 8;
  localparam int NG  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NM-1:0] mst_priv = '0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_super = 1'b0, req_trusted = 1'b0;
  logic [SW-1:0] req_slot = '0;
  logic [MW-1:0] req_master = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_err, per_start, per_write;
  logic [SW-1:0] per_slot;

  always #(CLK_PERIOD / 2) clk = ~clk;

  periph_guard #(.NUM_SLOTS(NS), .SLOT_W(SW), .NUM_MASTERS(NM), .MST_W(MW), .CFG_AW(AW)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata, .mst_priv,
    .req_valid, .req_ready, .req_slot, .req_write, .req_super, .req_trusted, .req_master,
    .rsp_valid, .rsp_ready, .rsp_err, .per_start, .per_slot, .per_write);

  int nchk = 0, nfail = 0;
  int m_prot [NS];
  bit m_rv, m_err, m_go, m_wr, m_acc;
  int m_slot;
  string m_tag = "R7";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_exp(int addr);
    logic [31:0] r = '0;
    if (addr >= 32 && addr % 4 == 0 && (addr - 32) / 4 < NG)
      for (int p = 0; p < 8; p++) begin
        int s = ((addr - 32) / 4) * 8 + p;
        if (s < NS) r |= 32'(m_prot[s]) << (28 - 4 * p);
      end
    return r;
  endfunction

  function automatic string why_fail();
    int s = int'(req_slot);
    if (s >= NS) return "R8";
    if ((m_prot[s] & 4) != 0 && !(req_super && mst_priv[req_master])) return "R4";
    if ((m_prot[s] & 2) != 0 && req_write) return "R5";
    if ((m_prot[s] & 1) != 0 && !req_trusted) return "R6";
    return "";
  endfunction

  task automatic cyc();
    string t;
    int ca;
    @(posedge clk);
    m_acc = 1'b0;
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) m_prot[s] = 4;
      m_rv = 0; m_err = 0; m_go = 0; m_wr = 0; m_slot = 0;
    end else begin
      t = why_fail();
      m_acc = req_valid && (!m_rv || rsp_ready);
      m_go = m_acc && (t == "");
      if (m_acc) begin
        m_rv = 1; m_err = (t != ""); m_slot = int'(req_slot); m_wr = req_write;
        m_tag = (t == "") ? "R7" : t;
      end else if (rsp_ready) m_rv = 0;
      ca = int'(cfg_addr);
      if (cfg_we && ca >= 32 && ca % 4 == 0 && (ca - 32) / 4 < NG)
        for (int p = 0; p < 8; p++) begin
          int s = ((ca - 32) / 4) * 8 + p;
          if (s < NS) m_prot[s] = int'((cfg_wdata >> (28 - 4 * p)) & 32'h7);
        end
    end
    @(negedge clk);
    if (rst_n) begin
      chk("R9", 32'(req_ready), 32'(!m_rv || rsp_ready));
      chk("R9", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk(m_tag, 32'(rsp_err), 32'(m_err));
      chk("R7", 32'(per_start), 32'(m_go));
      if (m_go) begin
        chk("R7", 32'(per_slot), 32'(m_slot));
        chk("R7", 32'(per_write), 32'(m_wr));
      end
      ca = int'(cfg_addr);
      chk((ca >= 32 && ca % 4 == 0 && (ca - 32) / 4 < NG) ? "R2" : "R3", cfg_rdata, rd_exp(ca));
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    cfg_addr = AW'(a); cfg_wdata = d; cfg_we = 1'b1;
    cyc();
    cfg_we = 1'b0;
    cyc();
  endtask

  task automatic send(int slot, bit wr, bit sup, bit tr, int mst);
    req_slot = SW'(slot); req_write = wr; req_super = sup; req_trusted = tr;
    req_master = MW'(mst); req_valid = 1'b1;
    for (int i = 0; i < 20 && !m_acc; i++) cyc();
    req_valid = 1'b0;
    cyc();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    // R1: reset contents, all three words
    for (int g = 0; g < NG; g++) begin
      cfg_addr = AW'(32 + 4 * g);
      #1 chk("R1", cfg_rdata, (g == 2) ? 32'h4444_0000 : 32'h4444_4444);
      cyc();
    end
    // R3: unmapped and misaligned reads and writes
    cfg_addr = 8'h2C; #1 chk("R3", cfg_rdata, 32'h0);
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    wr_reg(8'h22, 32'hFFFF_FFFF);
    wr_reg(8'h2C, 32'hFFFF_FFFF);
    cfg_addr = 8'h20; #1 chk("R3", cfg_rdata, 32'h4444_4444);
    // R2: reserved and unimplemented nibbles
    wr_reg(8'h20, 32'hFFFF_FFFF);
    #1 chk("R2", cfg_rdata, 32'h7777_7777);
    wr_reg(8'h28, 32'hFFFF_FFFF);
    #1 chk("R2", cfg_rdata, 32'h7777_0000);
    wr_reg(8'h28, 32'h4444_4444);
    // R4: supervisor-only slot 9 at reset value
    mst_priv = 4'b0010;
    send(9, 0, 0, 1, 1);
    send(9, 0, 1, 1, 0);
    send(9, 0, 1, 1, 1);
    // slot0 open, slot1 write-protected, slot2 trusted-only
    wr_reg(8'h20, 32'h0210_0000);
    send(1, 1, 0, 1, 0);   // R5 write refused
    send(1, 0, 0, 1, 0);   // R5 read allowed
    send(2, 0, 0, 0, 0);   // R6 untrusted refused
    send(2, 1, 0, 1, 0);   // R6 trusted allowed
    send(0, 1, 0, 0, 3);   // R7 open slot
    send(20, 0, 1, 1, 1);  // R8 beyond count
    send(31, 0, 1, 1, 1);  // R8
    // R9: backpressure holds the response and stalls the next request
    rsp_ready = 1'b0;
    send(0, 0, 0, 0, 0);
    req_slot = 5'd1; req_valid = 1'b1; req_write = 1'b1;
    repeat (4) cyc();
    rsp_ready = 1'b1;
    for (int i = 0; i < 10 && !m_acc; i++) cyc();
    req_valid = 1'b0;
    cyc();
    // mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = AW'($urandom_range(24, 48));
        cfg_wdata = $urandom();
      end else begin
        cfg_we = 1'b0;
        cfg_addr = AW'(32 + 4 * $urandom_range(0, 3));
      end
      rsp_ready = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) mst_priv = NM'($urandom());
      if (!req_valid && $urandom_range(0, 9) < 7) begin
        req_slot = SW'($urandom_range(0, 23));
        req_write = $urandom_range(0, 1) == 1;
        req_super = $urandom_range(0, 1) == 1;
        req_trusted = $urandom_range(0, 1) == 1;
        req_master = MW'($urandom());
        req_valid = 1'b1;
      end
      cyc();
      if (m_acc) req_valid = 1'b0;
    end
    cfg_we = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) cyc();
    finish_run();
  end
endmodule